// File: doc/BRIEF.md
# Data Rate Frequency Ratio Counter

This block finds the ratio between an unknown recovered data rate and a known reference frequency. Over a gate window, it counts the cycles in which a data-event strobe is high. The window is a power of two of reference ticks, and its length depends on a 2-bit reference-range select. With the default base exponent of 14, the data rate in Mb/s equals `result × f_ref / 2^(14 + sel)`. For example, a 32 MHz reference with select 1 and a 1.25 Gb/s stream give 0x138800. Select values 0 to 3 stand for reference bands of 10–20, 20–40, 40–80 and 80–160 MHz.

Both the data-event strobe and the reference tick are single-bit strobes that are already synchronous to the counter clock. Software keeps a level enable set and starts each measurement by writing the restart control high and then low. It polls a done flag and then reads the result as three bytes. The result only counts as trustworthy while the loss-of-lock input is low, and the block reports that condition on its own output.

Top module: `rate_ratio_counter`

## Requirements
- R1: After reset, `done` and `rate_ok` are 0, and all three result bytes are 0.
- R2: While `meas_en` is 1 and `lock_ref_en` is 0, a 1-to-0 change on `restart` starts a measurement and clears `done` at the same clock edge. `done` stays 0 for as long as the measurement runs.
- R3: The first cycle of the window is the cycle after the clock edge that detected the 1-to-0 change of `restart`. The window ends at the edge that samples the 2^(BASE_EXP+sel)-th `ref_tick`. The result is the number of cycles with `data_evt` high from the window's first cycle up to and including that last edge. `done` becomes 1 at that edge. `sel` is `range_sel`, captured when the measurement starts. Later changes to `range_sel` have no effect on that measurement.
- R4: `meas_en` is a level. Back-to-back measurements need only restart pulses, and `meas_en` stays 1 throughout.
- R5: The result is 23 bits wide. `freq_hi[6:0]` holds bits 22..16, `freq_mid` holds bits 15..8 and `freq_lo` holds bits 7..0.
- R6: When the event count exceeds the counter width (CNT_W bits), the result saturates at all ones. It does not wrap.
- R7: The result holds its value after a measurement completes. It does not change during the next measurement until that measurement completes.
- R8: A restart 1-to-0 change while `meas_en` is 0 or `lock_ref_en` is 1 starts no measurement and leaves `done` at 0. If `meas_en` falls during a measurement, the measurement is dropped and `done` stays 0.
- R9: While `meas_en` and `lock_ref_en` are both 1, `done` reads 0. Once `lock_ref_en` is cleared, a completed result shows `done` as 1 again.
- R10: `rate_ok` is 1 exactly when `done` is 1 and `lol` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| meas_en | input | 1 | Level enable for measurements |
| lock_ref_en | input | 1 | Lock-to-reference mode bit; conflicts with measurement |
| restart | input | 1 | Measurement restart control; acts on its 1-to-0 change |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| data_evt | input | 1 | One-cycle strobe per counted data event |
| range_sel | input | 2 | Reference band select, picks the gate exponent |
| lol | input | 1 | Loss-of-lock indication |
| done | output | 1 | Measurement complete, result readable |
| rate_ok | output | 1 | Result complete and lock held |
| freq_hi | output | 7 | Result bits 22..16 |
| freq_mid | output | 8 | Result bits 15..8 |
| freq_lo | output | 8 | Result bits 7..0 |

## Verification
An off-by-one in the gate timer moves the result by the number of events in one reference period. That error shows up the moment `done` rises, so the bench uses patterns with a different event density in each table row. A lost or stale captured range select gives a window of the wrong power of two, which doubles or halves the result on the first completion. A bad restart detector or abort path shows as `done` rising when it must not, or the held result changing within a few cycles. An accumulator that wraps gives a small result where all ones was expected.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int FREQ_W = 23;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rrc_state_e;
endpackage

// File: rtl/rrc_fall_det.sv
module rrc_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= din;
  end

  assign fall = prev_q & ~din;
endmodule

// File: rtl/rrc_gate_timer.sv
module rrc_gate_timer #(
  parameter int BASE_EXP = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       last
);
  localparam int TW = BASE_EXP + 3;

  logic [TW-1:0] cnt_q, cnt_d, limit;
  logic          cnt_en;

  always_comb begin
    limit  = {TW{1'b1}} >> (2'd3 - sel);
    cnt_en = clear | (run & tick);
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
    last   = run & tick & (cnt_q == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rrc_sat_acc.sv
module rrc_sat_acc #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  input  logic         evt,
  output logic [W-1:0] acc_next
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] acc_q;
  logic         acc_en;

  always_comb begin
    acc_en = clear | run;
    if (clear)                           acc_next = '0;
    else if (run && evt && acc_q != TOP) acc_next = acc_q + 1'b1;
    else                                 acc_next = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_next;
  end
endmodule

// File: rtl/rate_ratio_counter.sv
module rate_ratio_counter #(
  parameter int BASE_EXP = 14,
  parameter int CNT_W    = 23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_en,
  input  logic       lock_ref_en,
  input  logic       restart,
  input  logic       ref_tick,
  input  logic       data_evt,
  input  logic [1:0] range_sel,
  input  logic       lol,
  output logic       done,
  output logic       rate_ok,
  output logic [6:0] freq_hi,
  output logic [7:0] freq_mid,
  output logic [7:0] freq_lo
);
  import rrc_pkg::*;

  logic             rs_meta_q, srst_n;
  logic             rst_fall, win_last, abort, start, clear;
  rrc_state_e       state_q, state_d;
  logic             done_q, done_d, res_en, sel_en;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] acc_next, res_q;
  logic [FREQ_W-1:0] res_wide;
  logic             run;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      srst_n    <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      srst_n    <= rs_meta_q;
    end
  end

  rrc_fall_det u_fall (
    .clk  (clk),
    .rst_n(srst_n),
    .din  (restart),
    .fall (rst_fall)
  );

  assign run = (state_q == ST_RUN);

  rrc_gate_timer #(.BASE_EXP(BASE_EXP)) u_timer (
    .clk  (clk),
    .rst_n(srst_n),
    .clear(clear),
    .run  (run),
    .tick (ref_tick),
    .sel  (sel_q),
    .last (win_last)
  );

  rrc_sat_acc #(.W(CNT_W)) u_acc (
    .clk     (clk),
    .rst_n   (srst_n),
    .clear   (clear),
    .run     (run),
    .evt     (data_evt),
    .acc_next(acc_next)
  );

  // next-state
  always_comb begin
    abort   = ~meas_en | lock_ref_en;
    start   = rst_fall & ~abort;
    clear   = start;
    sel_en  = start;
    state_d = state_q;
    done_d  = done_q;
    res_en  = 1'b0;
    if (rst_fall) begin
      done_d  = 1'b0;
      state_d = abort ? ST_IDLE : ST_RUN;
    end else if (run && abort) begin
      state_d = ST_IDLE;
    end else if (win_last) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
      res_en  = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     sel_q <= 2'd0;
    else if (sel_en) sel_q <= range_sel;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     res_q <= '0;
    else if (res_en) res_q <= acc_next;
  end

  always_comb begin
    res_wide              = '0;
    res_wide[CNT_W-1:0]   = res_q;
  end

  assign freq_hi  = res_wide[22:16];
  assign freq_mid = res_wide[15:8];
  assign freq_lo  = res_wide[7:0];
  assign done     = done_q & ~(meas_en & lock_ref_en);
  assign rate_ok  = done & ~lol;
endmodule

// File: rtl/rate_ratio_counter_chk.sv
module rate_ratio_counter_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       meas_en,
  input logic       lock_ref_en,
  input logic       lol,
  input logic       done,
  input logic       rate_ok,
  input logic       done_q,
  input logic       run,
  input logic       rst_fall,
  input logic [6:0] freq_hi,
  input logic [7:0] freq_mid,
  input logic [7:0] freq_lo
);
  // R2
  restart_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rst_fall |=> !done_q);

  // R2
  run_nodone_chk: assert property (@(posedge clk) disable iff (!srst_n)
    run |-> !done_q);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !$rose(done_q) |-> $stable({freq_hi, freq_mid, freq_lo}));

  // R9
  lockref_done_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (meas_en && lock_ref_en) |-> !done);

  // R10
  rate_ok_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rate_ok |-> (done && !lol));
endmodule

bind rate_ratio_counter rate_ratio_counter_chk u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .meas_en    (meas_en),
  .lock_ref_en(lock_ref_en),
  .lol        (lol),
  .done       (done),
  .rate_ok    (rate_ok),
  .done_q     (done_q),
  .run        (run),
  .rst_fall   (rst_fall),
  .freq_hi    (freq_hi),
  .freq_mid   (freq_mid),
  .freq_lo    (freq_lo)
);

// File: tb/tb_rate_ratio_counter.sv
module tb_rate_ratio_counter;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 4;
  localparam int CW         = 12;
  localparam int SATV       = (1 << CW) - 1;
  localparam int NVEC       = 6;
  // {sel, tick period, event period, event-high cycles per period}
  localparam int VEC [NVEC][4] = '{
    '{0, 1, 1, 1},
    '{1, 2, 3, 1},
    '{2, 3, 5, 2},
    '{3, 5, 2, 1},
    '{3, 33, 1, 1},
    '{0, 7, 4, 3}
  };

  logic       clk, rst_n, meas_en, lock_ref_en, restart, ref_tick, data_evt, lol;
  logic [1:0] range_sel;
  logic       done, rate_ok;
  logic [6:0] freq_hi;
  logic [7:0] freq_mid, freq_lo;

  int total, bad, expv;
  int last_res;
  bit ended;

  rate_ratio_counter #(.BASE_EXP(BASE), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .lock_ref_en(lock_ref_en),
    .restart(restart), .ref_tick(ref_tick), .data_evt(data_evt),
    .range_sel(range_sel), .lol(lol), .done(done), .rate_ok(rate_ok),
    .freq_hi(freq_hi), .freq_mid(freq_mid), .freq_lo(freq_lo)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int res_now();
    return int'({freq_hi, freq_mid, freq_lo});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run_meas(input int sel, input int tk, input int ev, input int on,
                          output int exp);
    int ticks, n, i;
    n = 1 << (BASE + sel);
    ticks = 0; exp = 0; i = 0;
    @(negedge clk) range_sel = sel[1:0]; restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    while (ticks < n) begin
      @(negedge clk);
      if (i == 1) begin
        chk(done == 1'b0, "R2", int'(done), 0);
        chk(res_now() == last_res, "R7", res_now(), last_res);
        range_sel = 2'(sel + 1);  // R3: must be ignored mid-run
      end
      ref_tick = ((i % tk) == 0);
      data_evt = ((i % ev) < on);
      if (data_evt && exp < SATV) exp++;
      if (ref_tick) ticks++;
      i++;
    end
    @(negedge clk) ref_tick = 1'b0; data_evt = 1'b0;
  endtask

  task automatic idle_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) ref_tick = 1'b1; data_evt = k[0];
    end
    @(negedge clk) ref_tick = 1'b0; data_evt = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    total = 0; bad = 0; ended = 1'b0; last_res = 0;
    rst_n = 1'b0; meas_en = 1'b0; lock_ref_en = 1'b0; restart = 1'b0;
    ref_tick = 1'b0; data_evt = 1'b0; lol = 1'b0; range_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(rate_ok == 1'b0, "R1 rate_ok", int'(rate_ok), 0);
    chk(res_now() == 0, "R1 result", res_now(), 0);

    // R3 R4 R5 R6: table walk, meas_en never cleared between runs
    meas_en = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      run_meas(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], expv);
      chk(done == 1'b1, "R3 done", int'(done), 1);
      chk(res_now() == expv, "R3/R4 result", res_now(), expv);
      if (v == 4) chk(res_now() == SATV, "R6 saturate", res_now(), SATV);
      chk(int'(freq_mid) == ((expv >> 8) & 255) && int'(freq_lo) == (expv & 255)
          && freq_hi == 7'd0, "R5 packing", res_now(), expv);
      last_res = res_now();
    end

    // R7: result held after done while events keep coming
    idle_ticks(40);
    chk(res_now() == last_res, "R7 hold", res_now(), last_res);

    // R10
    lol = 1'b1; #1;
    chk(rate_ok == 1'b0 && done == 1'b1, "R10 lol high", int'(rate_ok), 0);
    lol = 1'b0; #1;
    chk(rate_ok == 1'b1, "R10 lol low", int'(rate_ok), 1);

    // R9: conflict masks done, clearing it brings done back
    @(negedge clk) lock_ref_en = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R9 masked", int'(done), 0);
    lock_ref_en = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R9 unmasked", int'(done), 1);

    // R8: restart with enable low
    meas_en = 1'b0;
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    idle_ticks(300);
    chk(done == 1'b0, "R8 en low", int'(done), 0);
    chk(res_now() == last_res, "R8 result kept", res_now(), last_res);

    // R8: restart with lock-to-reference set
    meas_en = 1'b1; lock_ref_en = 1'b1;
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    idle_ticks(300);
    lock_ref_en = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R8 lockref", int'(done), 0);

    // R8: enable dropped mid-run
    range_sel = 2'd3;
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    idle_ticks(10);
    meas_en = 1'b0;
    idle_ticks(300);
    meas_en = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R8 abort", int'(done), 0);
    chk(res_now() == last_res, "R8 abort result", res_now(), last_res);

    // R3: a fresh measurement still works after the abort
    run_meas(1, 1, 2, 1, expv);
    chk(done == 1'b1 && res_now() == expv, "R3 after abort", res_now(), expv);

    finish_run();
  end
endmodule